// File: doc/BRIEF.md
# I2C Bus Idle Watchdog with Stuck-Bus Recovery

This block watches the synchronized SCL and SDA lines of a local I2C bus and measures how long neither line has changed. If the bus stays quiet past a timeout, the block acts on the SDA level it sees at that moment. A high SDA means the bus can be reported as free. A low SDA means a slave is probably holding the bus after a transaction that ended badly. In that case the block clocks SCL so the slave can shift out the rest of its byte and release SDA.

Two timeouts are available: a long one, nominally one second, and a short one, nominally fifty microseconds. The short one is selected with a speed-up input. Both are set in microseconds and converted into system clock cycles from the clock frequency parameter. A disable input freezes the timer, stops any recovery in progress and prevents the bus from being declared free. The block never drives SCL high. It only asserts a pull-low enable, which the pad logic turns into an open-drain low.

Top module: `i2c_idle_watchdog`

## Requirements
- R1: While reset is held and on the first cycle after it, `bus_free_o`, `scl_pull_o` and `rec_active_o` are all 0.
- R2: A change on either SCL or SDA, sampled on a clock edge while no recovery runs, restarts the idle count and clears `bus_free_o` on that edge.
- R3: With `wd_fast_i` = 0, the timeout fires on the SLOW_CYC-th clock edge after the edge that saw the last line change, where SLOW_CYC = (CLK_HZ/1e6) * SLOW_US.
- R4: With `wd_fast_i` = 1, the same count uses FAST_CYC = (CLK_HZ/1e6) * FAST_US.
- R5: If SDA is 1 when the timeout fires, `bus_free_o` goes to 1 and stays 1 until the next line change.
- R6: If SDA is 0 when the timeout fires, `rec_active_o` rises and the block produces REC_PULSES (default 9) SCL clocks. Each clock starts with REC_HALF_CYC cycles of `scl_pull_o` = 1, followed by REC_HALF_CYC cycles of `scl_pull_o` = 0.
- R7: If SDA is sampled 1 in any cycle of a high phase, recovery ends at once, `rec_active_o` goes to 0 and `bus_free_o` goes to 1.
- R8: If SDA stays 0 through all high phases, recovery ends after the last high phase with `bus_free_o` = 0. The idle count then restarts, so the next timeout fires FAST_CYC (or SLOW_CYC) edges later.
- R9: While `wd_disable_i` = 1, no timeout fires, `bus_free_o` never rises, and any recovery stops, with `scl_pull_o` and `rec_active_o` at 0 from the next edge.
- R10: `scl_pull_o` is 1 only while `rec_active_o` is 1. SCL is never driven high.
- R11: Line changes seen during a recovery, including an SDA glitch in a low phase, neither restart the count nor cut the pulse train short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| wd_disable_i | input | 1 | 1 stops all watchdog action |
| wd_fast_i | input | 1 | 1 selects the short timeout |
| bus_free_o | output | 1 | Bus judged free after idle or recovery |
| scl_pull_o | output | 1 | Pull-low enable for SCL during recovery |
| rec_active_o | output | 1 | Recovery pulse train in progress |

## Verification
The bench checks the idle count exactly at both timeout lengths. An off-by-one in the limit or in the restart would move the rise of `bus_free_o` by a cycle. The bench restarts the count from SCL as well as from SDA; a design that watched only one line would go free too early. A stuck slave that never lets go must receive exactly nine clocks with the correct phase lengths, and `bus_free_o` must stay low afterwards. A slave that lets go on the third clock must end recovery on the third high phase. The bench also injects an SDA glitch in a low phase, which a design that checked SDA outside high phases would take as an early abort. Raising the disable input in the middle of the pulse train must release SCL on the next edge rather than finishing the train.

// File: rtl/i2c_wdog_pkg.sv
package i2c_wdog_pkg;

  typedef enum logic [1:0] {
    REC_IDLE = 2'd0,
    REC_LOW  = 2'd1,
    REC_HIGH = 2'd2
  } rec_state_e;

  function automatic int unsigned us_to_cycles(input int unsigned hz, input int unsigned us);
    return (hz / 1000000) * us;
  endfunction

endpackage

// File: rtl/i2c_wdog_edge.sv
module i2c_wdog_edge #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lines_i,
  output logic             change_o
);

  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] diff;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b1;
      else     prev_q[g] <= lines_i[g];
    end
    assign diff[g] = lines_i[g] ^ prev_q[g];
  end

  assign change_o = |diff;

endmodule

// File: rtl/i2c_wdog_timer.sv
module i2c_wdog_timer #(
  parameter int unsigned SLOW_CYC = 1000,
  parameter int unsigned FAST_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  input  logic fast_i,
  output logic expired_o
);

  localparam int unsigned TOP_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int W = $clog2(TOP_CYC + 1);
  localparam logic [W-1:0] SLOW_LAST = W'(SLOW_CYC - 1);
  localparam logic [W-1:0] FAST_LAST = W'(FAST_CYC - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] limit;

  assign limit     = fast_i ? FAST_LAST : SLOW_LAST;
  assign expired_o = run_i && !clear_i && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear_i)  cnt_q <= '0;
    else if (expired_o)  cnt_q <= '0;
    else if (run_i)      cnt_q <= cnt_q + 1'b1;
  end

  // R3: the count never passes the longer limit
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= W'(TOP_CYC - 1));

  // R2: a clear leaves the count at zero on the next edge
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/i2c_wdog_recovery.sv
module i2c_wdog_recovery
  import i2c_wdog_pkg::*;
#(
  parameter int unsigned HALF_CYC = 250,
  parameter int unsigned PULSES   = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic sda_i,
  input  logic kill_i,
  output logic pull_o,
  output logic active_o,
  output logic freed_o
);

  localparam int PW = $clog2(HALF_CYC + 1);
  localparam int CW = $clog2(PULSES + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(HALF_CYC - 1);
  localparam logic [CW-1:0] PC_LAST = CW'(PULSES - 1);

  rec_state_e    state_q;
  logic [PW-1:0] ph_q;
  logic [CW-1:0] pc_q;

  assign active_o = (state_q != REC_IDLE);
  assign freed_o  = (state_q == REC_HIGH) && sda_i && !kill_i;

  always_ff @(posedge clk) begin
    if (rst || kill_i) begin
      state_q <= REC_IDLE;
      ph_q    <= '0;
      pc_q    <= '0;
      pull_o  <= 1'b0;
    end else begin
      unique case (state_q)
        REC_IDLE: begin
          if (start_i) begin
            state_q <= REC_LOW;
            ph_q    <= '0;
            pc_q    <= '0;
            pull_o  <= 1'b1;
          end
        end
        REC_LOW: begin
          if (ph_q == PH_LAST) begin
            ph_q    <= '0;
            state_q <= REC_HIGH;
            pull_o  <= 1'b0;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        REC_HIGH: begin
          if (sda_i) begin
            state_q <= REC_IDLE;
            ph_q    <= '0;
            pc_q    <= '0;
          end else if (ph_q == PH_LAST) begin
            ph_q <= '0;
            if (pc_q == PC_LAST) begin
              state_q <= REC_IDLE;
              pc_q    <= '0;
            end else begin
              pc_q    <= pc_q + 1'b1;
              state_q <= REC_LOW;
              pull_o  <= 1'b1;
            end
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: begin
          state_q <= REC_IDLE;
          pull_o  <= 1'b0;
        end
      endcase
    end
  end

  // R10: the pull-low enable only appears in a low phase
  p_pull_in_low_r10: assert property (@(posedge clk) disable iff (rst)
    pull_o |-> (state_q == REC_LOW));

  // R6: pulse index stays below the pulse count
  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (rst)
    pc_q <= PC_LAST);

  // R9: disable releases SCL on the next edge
  p_kill_release_r9: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> (!pull_o && state_q == REC_IDLE));

  // R7: SDA high in a high phase ends the train
  p_abort_r7: assert property (@(posedge clk) disable iff (rst)
    ((state_q == REC_HIGH) && sda_i && !kill_i) |=> (state_q == REC_IDLE));

endmodule

// File: rtl/i2c_idle_watchdog.sv
module i2c_idle_watchdog
  import i2c_wdog_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 50000000,
  parameter int unsigned SLOW_US      = 1000000,
  parameter int unsigned FAST_US      = 50,
  parameter int unsigned REC_HALF_CYC = 250,
  parameter int unsigned REC_PULSES   = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wd_disable_i,
  input  logic wd_fast_i,
  output logic bus_free_o,
  output logic scl_pull_o,
  output logic rec_active_o
);

  localparam int unsigned SLOW_CYC = us_to_cycles(CLK_HZ, SLOW_US);
  localparam int unsigned FAST_CYC = us_to_cycles(CLK_HZ, FAST_US);

  logic line_change;
  logic expired;
  logic rec_freed;
  logic tmr_clear;
  logic tmr_run;

  i2c_wdog_edge #(.LINES(2)) edge_i (
    .clk      (clk),
    .rst      (rst),
    .lines_i  ({scl_i, sda_i}),
    .change_o (line_change)
  );

  assign tmr_clear = line_change || wd_disable_i || rec_active_o;
  assign tmr_run   = !bus_free_o && !rec_active_o && !wd_disable_i;

  i2c_wdog_timer #(.SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (tmr_clear),
    .run_i     (tmr_run),
    .fast_i    (wd_fast_i),
    .expired_o (expired)
  );

  i2c_wdog_recovery #(.HALF_CYC(REC_HALF_CYC), .PULSES(REC_PULSES)) rec_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (expired && !sda_i),
    .sda_i    (sda_i),
    .kill_i   (wd_disable_i),
    .pull_o   (scl_pull_o),
    .active_o (rec_active_o),
    .freed_o  (rec_freed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_free_o <= 1'b0;
    end else if (wd_disable_i) begin
      if (line_change) bus_free_o <= 1'b0;
    end else if (rec_active_o) begin
      if (rec_freed) bus_free_o <= 1'b1;
    end else if (line_change) begin
      bus_free_o <= 1'b0;
    end else if (expired && sda_i) begin
      bus_free_o <= 1'b1;
    end
  end

  // R2: a line change outside recovery clears the free flag
  p_change_clears_free_r2: assert property (@(posedge clk) disable iff (rst)
    (line_change && !rec_active_o) |=> !bus_free_o);

  // R10: SCL pull only while recovery is flagged
  p_pull_needs_active_r10: assert property (@(posedge clk) disable iff (rst)
    scl_pull_o |-> rec_active_o);

  // R8: free and recovering never coincide
  p_free_rec_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(bus_free_o && rec_active_o));

  // R9: disabled watchdog never raises the free flag
  p_disable_no_free_r9: assert property (@(posedge clk) disable iff (rst)
    (wd_disable_i && !bus_free_o) |=> !bus_free_o);

  // R6: a recovery starts with SCL pulled low
  p_rec_starts_low_r6: assert property (@(posedge clk) disable iff (rst)
    (!rec_active_o ##1 rec_active_o) |-> scl_pull_o);

endmodule

// File: tb/i2c_idle_watchdog_tb_top.sv
module i2c_idle_watchdog_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HZ    = 1000000;
  localparam int SLOW  = 400;
  localparam int FAST  = 50;
  localparam int HALF  = 4;
  localparam int NPULS = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bench_scl = 1'b1;
  logic bench_sda = 1'b1;
  logic wd_disable = 1'b0;
  logic wd_fast = 1'b0;
  logic bus_free_o, scl_pull_o, rec_active_o;
  logic scl_line;

  assign scl_line = bench_scl & ~scl_pull_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_idle_watchdog #(
    .CLK_HZ(HZ), .SLOW_US(SLOW), .FAST_US(FAST),
    .REC_HALF_CYC(HALF), .REC_PULSES(NPULS)
  ) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(bench_sda),
    .wd_disable_i(wd_disable), .wd_fast_i(wd_fast),
    .bus_free_o(bus_free_o), .scl_pull_o(scl_pull_o), .rec_active_o(rec_active_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";

  // reference model state
  int m_sclq = 1, m_sdaq = 1, m_cnt = 0, m_free = 0, m_st = 0, m_ph = 0, m_pc = 0, m_pull = 0;
  // stuck slave model
  int slave_hold = 0, slave_rel = 0, slave_falls = 0, prev_line = 1;
  int bad_pull = 0;

  task automatic check_eq(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic model_step();
    int scl_in, sda_in, lim;
    bit chg;
    scl_in = (bench_scl && (m_pull == 0)) ? 1 : 0;
    sda_in = bench_sda ? 1 : 0;
    chg = (scl_in != m_sclq) || (sda_in != m_sdaq);
    m_sclq = scl_in;
    m_sdaq = sda_in;
    lim = wd_fast ? FAST : SLOW;
    if (rst) begin
      m_sclq = 1; m_sdaq = 1; m_cnt = 0; m_free = 0; m_st = 0; m_ph = 0; m_pc = 0; m_pull = 0;
    end else if (wd_disable) begin
      m_cnt = 0; m_st = 0; m_ph = 0; m_pc = 0; m_pull = 0;
      if (chg) m_free = 0;
    end else if (m_st == 1) begin
      if (m_ph == HALF - 1) begin m_ph = 0; m_st = 2; m_pull = 0; end
      else m_ph++;
    end else if (m_st == 2) begin
      if (sda_in == 1) begin m_st = 0; m_ph = 0; m_pc = 0; m_free = 1; end
      else if (m_ph == HALF - 1) begin
        m_ph = 0;
        if (m_pc == NPULS - 1) begin m_st = 0; m_pc = 0; end
        else begin m_pc++; m_st = 1; m_pull = 1; end
      end else m_ph++;
    end else begin
      if (chg) begin m_cnt = 0; m_free = 0; end
      else if (m_free == 1) begin end
      else if (m_cnt >= lim - 1) begin
        m_cnt = 0;
        if (sda_in == 1) m_free = 1;
        else begin m_st = 1; m_ph = 0; m_pc = 0; m_pull = 1; end
      end else m_cnt++;
    end
  endtask

  task automatic tick();
    int line;
    @(negedge clk);
    model_step();
    check_eq({cur_req, " bus_free_o vs model"}, int'(bus_free_o), m_free);
    check_eq({cur_req, " scl_pull_o vs model"}, int'(scl_pull_o), m_pull);
    check_eq({cur_req, " rec_active_o vs model"}, int'(rec_active_o), (m_st != 0) ? 1 : 0);
    if (scl_pull_o && !rec_active_o) bad_pull++;
    line = scl_line ? 1 : 0;
    if (slave_hold != 0 && prev_line == 1 && line == 0) begin
      slave_falls++;
      if (slave_falls == slave_rel) begin bench_sda = 1'b1; slave_hold = 0; end
    end
    prev_line = line;
  endtask

  task automatic pulse_sda();
    bench_sda = 1'b0; tick(); bench_sda = 1'b1;
  endtask

  task automatic ticks_to_free(output int n);
    n = 0;
    while (!bus_free_o && n < 2000) begin tick(); n++; end
  endtask

  task automatic ticks_to_active(output int n);
    n = 0;
    while (!rec_active_o && n < 2000) begin tick(); n++; end
  endtask

  task automatic run_train(input bit glitch, output int pulses, output int low_len, output int high_len);
    int prev;
    bit glitched;
    prev = 0; pulses = 0; low_len = 0; high_len = 0; glitched = 0;
    while (rec_active_o) begin
      if (scl_pull_o && prev == 0) pulses++;
      if (pulses == 1 && scl_pull_o) low_len++;
      if (pulses == 1 && !scl_pull_o) high_len++;
      if (glitch && !glitched && pulses == 2 && scl_pull_o) begin
        bench_sda = 1'b1; tick(); bench_sda = 1'b0; glitched = 1; prev = 1;
      end else begin
        prev = scl_pull_o; tick();
      end
    end
  endtask

  initial begin
    int n, p, lo, hi;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check_eq("R1 bus_free_o after reset", int'(bus_free_o), 0);
    check_eq("R1 scl_pull_o after reset", int'(scl_pull_o), 0);
    check_eq("R1 rec_active_o after reset", int'(rec_active_o), 0);

    // slow timeout with SDA high
    cur_req = "R3";
    pulse_sda();
    ticks_to_free(n);
    check_eq("R3 slow timeout length", n, SLOW + 1);
    cur_req = "R5";
    repeat (20) tick();
    check_eq("R5 bus_free_o held", int'(bus_free_o), 1);

    // change clears free, SCL restarts count
    cur_req = "R2";
    bench_sda = 1'b0; tick();
    check_eq("R2 SDA change clears free", int'(bus_free_o), 0);
    bench_sda = 1'b1;
    repeat (300) tick();
    bench_scl = 1'b0; tick(); bench_scl = 1'b1;
    ticks_to_free(n);
    check_eq("R2 SCL change restarts count", n, SLOW + 1);

    // fast timeout
    cur_req = "R4";
    wd_fast = 1'b1;
    pulse_sda();
    ticks_to_free(n);
    check_eq("R4 fast timeout length", n, FAST + 1);

    // stuck slave, never releases, with glitch in a low phase
    cur_req = "R6";
    bench_sda = 1'b0;
    ticks_to_active(n);
    check_eq("R6 recovery starts after timeout", n, FAST + 1);
    check_eq("R6 first phase pulls low", int'(scl_pull_o), 1);
    cur_req = "R11";
    run_train(1'b1, p, lo, hi);
    check_eq("R6 pulse count", p, NPULS);
    check_eq("R6 low phase length", lo, HALF);
    check_eq("R6 high phase length", hi, HALF);
    check_eq("R11 glitch did not abort", int'(bus_free_o), 0);
    cur_req = "R8";
    check_eq("R8 bus not free after full train", int'(bus_free_o), 0);
    ticks_to_active(n);
    check_eq("R8 count restarts after train", n, FAST);

    // slave releases on third clock
    cur_req = "R7";
    slave_hold = 1; slave_rel = 3; slave_falls = 1; prev_line = 0;
    run_train(1'b0, p, lo, hi);
    check_eq("R7 pulses before abort", p, 3);
    check_eq("R7 bus free after abort", int'(bus_free_o), 1);
    check_eq("R7 SCL released", int'(scl_pull_o), 0);

    // disable
    cur_req = "R9";
    wd_disable = 1'b1;
    pulse_sda();
    repeat (SLOW + 20) tick();
    check_eq("R9 no free while disabled", int'(bus_free_o), 0);
    wd_disable = 1'b0;
    bench_sda = 1'b0;
    ticks_to_active(n);
    repeat (6) tick();
    wd_disable = 1'b1;
    tick();
    check_eq("R9 disable releases SCL", int'(scl_pull_o), 0);
    check_eq("R9 disable stops recovery", int'(rec_active_o), 0);
    repeat (3 * FAST) tick();
    check_eq("R9 no restart while disabled", int'(rec_active_o), 0);
    wd_disable = 1'b0;
    bench_sda = 1'b1;
    repeat (5) tick();

    check_eq("R10 pull seen only with recovery active", bad_pull, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule